// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Level Trigger

This block buffers received characters between a serial receiver and the CPU-side register file of a UART. Each slot holds one data byte together with the three error flags that the receiver attached to that character. The CPU reads the oldest character and pops it with a single read strobe. When queue mode is off, the same storage acts as a one-character holding register.

The block tells the CPU when there is enough data to service in three ways. A level interrupt is raised once the fill count reaches a trigger level that software picks from four values. A ready pin, active low, has hysteresis: it asserts at the trigger level and releases only when the queue has drained. A character time-out flags data that sits below the trigger level with no traffic in either direction. Two status bits complete the picture: one says data is waiting, and one is a sticky summary of errors over every character still held. A clear request empties the queue without touching the receiver, and a sticky overrun flag records every character dropped because the queue was full.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset, data_ready, fifo_err, rx_int, timeout and overrun are 0, rxrdy_n is 1 and rd_data is 0.
- R2: With fifo_en=1, characters come out in the order they were written. rd_data and rd_flags show the oldest held character, and a cycle with rd_strobe=1 removes it. A write and a read in the same cycle are both performed.
- R3: The capacity is DEPTH (16) characters with fifo_en=1 and 1 with fifo_en=0. A write into a full store is dropped, leaves the held contents unchanged, and sets overrun. overrun stays 1 until a clear or reset.
- R4: trig_sel selects the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. With fifo_en=1, rx_int is 1 exactly when the fill count is at or above that level.
- R5: rxrdy_n goes to 0 in the cycle the fill count reaches the trigger level. After that it returns to 1 only when the store is empty.
- R6: The flag bits are [0] parity error, [1] framing error and [2] break. fifo_err is 1 while at least one held character has any flag set.
- R7: data_ready is 1 exactly when at least one character is held.
- R8: A cycle with fifo_clr=1 empties the store and clears overrun, fifo_err and timeout. rd_data keeps the last value that was read.
- R9: With fifo_en=1 and the store not empty, timeout rises 4*CHAR_CLKS cycles after the last write or read. The next write, read or clear drops it.
- R10: A read strobe while empty changes neither rd_data nor the fill state.
- R11: With fifo_en=0, rx_int follows data_ready, rxrdy_n is its inverse and timeout stays 0. Any change of fifo_en empties the store the same way a clear does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Receiver delivers a character this cycle |
| wr_data | input | 8 | Received byte |
| wr_flags | input | 3 | Per-character flags: [0] parity, [1] framing, [2] break |
| rd_strobe | input | 1 | CPU reads and pops the oldest character |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single holding register |
| fifo_clr | input | 1 | One-cycle request to empty the store |
| trig_sel | input | 2 | Trigger level select |
| rd_data | output | 8 | Oldest held byte, or the last read byte when empty |
| rd_flags | output | 3 | Flags belonging to rd_data |
| data_ready | output | 1 | At least one character held |
| fifo_err | output | 1 | Some held character carries an error flag |
| rx_int | output | 1 | Fill level at or above the trigger level |
| rxrdy_n | output | 1 | Ready pin with hysteresis, active low |
| timeout | output | 1 | Character time-out |
| overrun | output | 1 | Sticky flag for a dropped write |

## Verification
The hardest state to reach is a completely full store that takes a further write in the same cycle nothing is read. Only this shows that the dropped byte leaves the held contents intact. The stimulus fills all sixteen slots with distinct bytes and offers one more. It then drains the store and compares every byte against its write order, and checks that the last value read is not the dropped byte. A second hard point is the error summary as errored characters move to the head and leave. The vector table interleaves flagged and clean bytes and includes a simultaneous write and read, so the summary has to rise and fall with the characters it covers.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int BYTE_W = 8;
    localparam int FLAG_W = 3;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [FLAG_W-1:0] flags;
    } rxf_entry_t;

endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic       clk,
    input  logic       we,
    input  logic [AW-1:0] waddr,
    input  rxf_entry_t wentry,
    input  logic [AW-1:0] raddr,
    output rxf_entry_t rentry
);

    rxf_entry_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wentry;
        end
    end

    assign rentry = mem_q[raddr];

endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
    parameter int DEPTH   = 16,
    parameter int CW      = 5,
    parameter int TRIG_L0 = 1,
    parameter int TRIG_L1 = 4,
    parameter int TRIG_L2 = 8,
    parameter int TRIG_L3 = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] cnt_q,
    input  logic [CW-1:0] cnt_d,
    output logic          rx_int,
    output logic          rxrdy_n
);

    typedef struct packed {
        logic rdy;
    } lvl_state_t;

    lvl_state_t s_d, s_q;
    logic [CW-1:0] lvl, eff_lvl;

    always_comb begin
        unique case (trig_sel)
            2'b00:   lvl = CW'(TRIG_L0);
            2'b01:   lvl = CW'(TRIG_L1);
            2'b10:   lvl = CW'(TRIG_L2);
            default: lvl = CW'(TRIG_L3);
        endcase
        eff_lvl = fifo_en ? lvl : CW'(1);

        s_d = s_q;
        if (cnt_d == '0) begin
            s_d.rdy = 1'b0;
        end else if (cnt_d >= eff_lvl) begin
            s_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_int  = (cnt_q >= eff_lvl);
    assign rxrdy_n = !s_q.rdy;

    // R5: the ready pin releases only on an empty store
    assert_rdy_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxrdy_n) |-> (cnt_q == '0));

    // R5: a level at or above the trigger holds the pin active
    assert_rdy_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q >= eff_lvl) && $stable(trig_sel) && $stable(fifo_en)) |-> !rxrdy_n);

endmodule

// File: rtl/rxf_timer.sv
module rxf_timer #(
    parameter int TO_CYCLES = 32,
    parameter int TW        = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic kick,
    output logic timeout
);

    typedef struct packed {
        logic [TW-1:0] timer;
        logic          fired;
    } tmr_state_t;

    localparam logic [TW-1:0] LAST = TW'(TO_CYCLES - 1);

    tmr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!arm || kick) begin
            s_d.timer = '0;
            s_d.fired = 1'b0;
        end else begin
            s_d.timer = (s_q.timer == LAST) ? s_q.timer : s_q.timer + TW'(1);
            s_d.fired = s_q.fired || (s_q.timer == LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign timeout = s_q.fired;

    // R9: activity always drops the time-out
    assert_to_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !timeout);

    // R9: the time-out never rises while disarmed
    assert_to_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> !timeout);

endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
    import rxf_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int CHAR_CLKS = 8,
    parameter int TRIG_L0   = 1,
    parameter int TRIG_L1   = 4,
    parameter int TRIG_L2   = 8,
    parameter int TRIG_L3   = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    input  logic [2:0]  wr_flags,
    input  logic        rd_strobe,
    input  logic        fifo_en,
    input  logic        fifo_clr,
    input  logic [1:0]  trig_sel,
    output logic [7:0]  rd_data,
    output logic [2:0]  rd_flags,
    output logic        data_ready,
    output logic        fifo_err,
    output logic        rx_int,
    output logic        rxrdy_n,
    output logic        timeout,
    output logic        overrun
);

    localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW        = $clog2(DEPTH + 1);
    localparam int TO_CYCLES = 4 * CHAR_CLKS;
    localparam int TW        = $clog2(TO_CYCLES);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
        logic [CW-1:0] err_cnt;
        logic          ovr;
        logic          en;
        rxf_entry_t    hold;
    } q_state_t;

    q_state_t   s_d, s_q;
    rxf_entry_t head, new_entry;
    logic       clr, do_push, do_pop;
    logic [CW-1:0] cap;

    always_comb begin
        new_entry.data  = wr_data;
        new_entry.flags = wr_flags;

        clr     = fifo_clr || (fifo_en != s_q.en);
        cap     = fifo_en ? CW'(DEPTH) : CW'(1);
        do_pop  = rd_strobe && (s_q.cnt != '0) && !clr;
        do_push = wr_valid && !clr && ((s_q.cnt < cap) || do_pop);

        s_d    = s_q;
        s_d.en = fifo_en;
        if (clr) begin
            s_d.wr_ptr  = '0;
            s_d.rd_ptr  = '0;
            s_d.cnt     = '0;
            s_d.err_cnt = '0;
            s_d.ovr     = 1'b0;
        end else begin
            if (do_push) begin
                s_d.wr_ptr = (s_q.wr_ptr == PTR_LAST) ? '0 : s_q.wr_ptr + AW'(1);
            end
            if (do_pop) begin
                s_d.rd_ptr = (s_q.rd_ptr == PTR_LAST) ? '0 : s_q.rd_ptr + AW'(1);
                s_d.hold   = head;
            end
            s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
            s_d.err_cnt = s_q.err_cnt
                        + CW'(do_push && (wr_flags != '0))
                        - CW'(do_pop && (head.flags != '0));
            if (wr_valid && !do_push) begin
                s_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    rxf_store #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) i_store (
        .clk    (clk),
        .we     (do_push),
        .waddr  (s_q.wr_ptr),
        .wentry (new_entry),
        .raddr  (s_q.rd_ptr),
        .rentry (head)
    );

    rxf_level #(
        .DEPTH   (DEPTH),
        .CW      (CW),
        .TRIG_L0 (TRIG_L0),
        .TRIG_L1 (TRIG_L1),
        .TRIG_L2 (TRIG_L2),
        .TRIG_L3 (TRIG_L3)
    ) i_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .trig_sel (trig_sel),
        .cnt_q    (s_q.cnt),
        .cnt_d    (s_d.cnt),
        .rx_int   (rx_int),
        .rxrdy_n  (rxrdy_n)
    );

    rxf_timer #(
        .TO_CYCLES (TO_CYCLES),
        .TW        (TW)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (fifo_en && (s_q.cnt != '0)),
        .kick    (do_push || do_pop || clr),
        .timeout (timeout)
    );

    assign rd_data    = (s_q.cnt != '0) ? head.data  : s_q.hold.data;
    assign rd_flags   = (s_q.cnt != '0) ? head.flags : s_q.hold.flags;
    assign data_ready = (s_q.cnt != '0);
    assign fifo_err   = (s_q.err_cnt != '0);
    assign overrun    = s_q.ovr;

    // R3: fill count never exceeds the capacity
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    // R3: a write into a full queue is dropped and flagged
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.cnt == CW'(DEPTH)) && wr_valid && !rd_strobe && !fifo_clr
         && fifo_en && s_q.en) |=> ((s_q.cnt == CW'(DEPTH)) && overrun));

    // R6: errored characters are a subset of held characters
    assert_err_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err_cnt <= s_q.cnt);

    // R8: a clear request leaves an empty, error-free store
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (!data_ready && !overrun && !fifo_err));

    // R10: reading an empty store keeps the output byte
    assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_ready && rd_strobe && !wr_valid && !fifo_clr) |=> $stable(rd_data));

    // R11: holding-register mode keeps at most one character
    assert_hold_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !s_q.en) |-> (s_q.cnt <= CW'(1)));

endmodule

// File: tb/test_rx_fifo_trig.sv
module test_rx_fifo_trig;

    localparam int CHAR = 8;
    localparam int TO   = 4 * CHAR;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] wr_flags = '0;
    logic       rd_strobe = 1'b0;
    logic       fifo_en = 1'b1;
    logic       fifo_clr = 1'b0;
    logic [1:0] trig_sel = 2'b01;
    logic [7:0] rd_data;
    logic [2:0] rd_flags;
    logic       data_ready, fifo_err, rx_int, rxrdy_n, timeout, overrun;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = !clk;

    rx_fifo_trig #(.DEPTH(16), .CHAR_CLKS(CHAR)) i_rx_fifo_trig (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_flags(wr_flags), .rd_strobe(rd_strobe), .fifo_en(fifo_en),
        .fifo_clr(fifo_clr), .trig_sel(trig_sel), .rd_data(rd_data),
        .rd_flags(rd_flags), .data_ready(data_ready), .fifo_err(fifo_err),
        .rx_int(rx_int), .rxrdy_n(rxrdy_n), .timeout(timeout), .overrun(overrun)
    );

    typedef struct packed {
        logic       push;
        logic [7:0] din;
        logic [2:0] flg;
        logic       pop;
        logic       dr;
        logic       irq;
        logic       rdyn;
        logic       err;
        logic [7:0] rd;
    } vec_t;

    // trigger level 4; flags [0] parity [1] framing [2] break
    localparam vec_t VEC [12] = '{
        '{1'b1, 8'hA1, 3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA1},
        '{1'b1, 8'hB2, 3'b001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA1},
        '{1'b1, 8'hC3, 3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA1},
        '{1'b1, 8'hD4, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hA1},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hB2},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3},
        '{1'b1, 8'hE5, 3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hD4},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hE5},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hE5},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hE5},
        '{1'b1, 8'h66, 3'b100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h66},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h66}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic push, input logic [7:0] d, input logic [2:0] f,
                       input logic pop, input logic clr);
        wr_valid  = push;
        wr_data   = d;
        wr_flags  = f;
        rd_strobe = pop;
        fifo_clr  = clr;
        @(posedge clk);
        #1;
        wr_valid  = 1'b0;
        rd_strobe = 1'b0;
        fifo_clr  = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 data_ready", data_ready, 0);
        check("R1 fifo_err", fifo_err, 0);
        check("R1 rx_int", rx_int, 0);
        check("R1 rxrdy_n", rxrdy_n, 1);
        check("R1 timeout", timeout, 0);
        check("R1 overrun", overrun, 0);
        check("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0);

        // table walk: R2 order, R4/R5 level and pin, R6 errors, R7, R10
        for (int i = 0; i < 12; i++) begin
            cyc(VEC[i].push, VEC[i].din, VEC[i].flg, VEC[i].pop, 0);
            check($sformatf("R7 vec%0d data_ready", i), data_ready, VEC[i].dr);
            check($sformatf("R4 vec%0d rx_int", i), rx_int, VEC[i].irq);
            check($sformatf("R5 vec%0d rxrdy_n", i), rxrdy_n, VEC[i].rdyn);
            check($sformatf("R6 vec%0d fifo_err", i), fifo_err, VEC[i].err);
            check($sformatf("R2 vec%0d rd_data", i), rd_data, VEC[i].rd);
        end
        check("R10 empty read keeps data", rd_data, 8'h66);

        // R4: trigger levels 1, 4, 8
        for (int s = 0; s < 3; s++) begin
            int lvl;
            lvl = (s == 0) ? 1 : (s == 1) ? 4 : 8;
            trig_sel = 2'(s);
            cyc(0, 0, 0, 0, 1);
            for (int k = 0; k < lvl - 1; k++) cyc(1, 8'(k), 0, 0, 0);
            check($sformatf("R4 sel%0d below level", s), rx_int, 0);
            cyc(1, 8'h5A, 0, 0, 0);
            check($sformatf("R4 sel%0d at level", s), rx_int, 1);
        end
        cyc(0, 0, 0, 0, 1);

        // R3 full store, R4 level 14
        trig_sel = 2'b11;
        for (int k = 0; k < 16; k++) begin
            cyc(1, 8'h30 + 8'(k), 3'(k % 2), 0, 0);
            if (k == 12) check("R4 sel3 count 13", rx_int, 0);
            if (k == 13) check("R4 sel3 count 14", rx_int, 1);
        end
        check("R3 no overrun before full", overrun, 0);
        cyc(1, 8'hEE, 3'b000, 0, 0);
        check("R3 overrun on full write", overrun, 1);
        check("R3 head unchanged", rd_data, 8'h30);
        for (int k = 0; k < 16; k++) begin
            check($sformatf("R2 drain byte %0d", k), rd_data, 8'h30 + 8'(k));
            check($sformatf("R6 drain flags %0d", k), rd_flags, 3'(k % 2));
            if (k == 15) check("R5 pin held until empty", rxrdy_n, 0);
            cyc(0, 0, 0, 1, 0);
        end
        check("R3 dropped byte never stored", rd_data, 8'h3F);
        check("R3 store empty after drain", data_ready, 0);
        check("R3 overrun sticky", overrun, 1);

        // R8: clear
        trig_sel = 2'b00;
        cyc(1, 8'h71, 3'b010, 0, 0);
        cyc(1, 8'h72, 3'b100, 0, 0);
        check("R8 pre-clear err", fifo_err, 1);
        cyc(0, 0, 0, 0, 1);
        check("R8 clear data_ready", data_ready, 0);
        check("R8 clear fifo_err", fifo_err, 0);
        check("R8 clear overrun", overrun, 0);
        check("R8 clear rxrdy_n", rxrdy_n, 1);
        check("R8 clear keeps rd_data", rd_data, 8'h3F);

        // R9: time-out
        trig_sel = 2'b01;
        cyc(1, 8'h81, 0, 0, 0);
        repeat (TO - 1) cyc(0, 0, 0, 0, 0);
        check("R9 no timeout before window", timeout, 0);
        cyc(0, 0, 0, 0, 0);
        check("R9 timeout at window", timeout, 1);
        cyc(1, 8'h82, 0, 0, 0);
        check("R9 write clears timeout", timeout, 0);
        repeat (TO) cyc(0, 0, 0, 0, 0);
        check("R9 timeout again", timeout, 1);
        cyc(0, 0, 0, 1, 0);
        check("R9 read clears timeout", timeout, 0);
        cyc(0, 0, 0, 0, 1);

        // R11: holding-register mode
        fifo_en = 1'b0;
        cyc(0, 0, 0, 0, 0);
        cyc(1, 8'h11, 0, 0, 0);
        check("R11 data_ready", data_ready, 1);
        check("R11 rx_int follows", rx_int, 1);
        check("R11 rxrdy_n", rxrdy_n, 0);
        cyc(1, 8'h22, 0, 0, 0);
        check("R3 holding overrun", overrun, 1);
        check("R3 holding keeps first", rd_data, 8'h11);
        repeat (TO + 4) cyc(0, 0, 0, 0, 0);
        check("R11 no timeout", timeout, 0);
        cyc(0, 0, 0, 1, 0);
        check("R11 pop empties", data_ready, 0);
        check("R11 rx_int off", rx_int, 0);
        check("R11 rxrdy_n off", rxrdy_n, 1);
        cyc(1, 8'h33, 0, 0, 0);
        fifo_en = 1'b1;
        cyc(0, 0, 0, 0, 0);
        check("R11 mode change empties", data_ready, 0);
        check("R11 mode change clears overrun", overrun, 0);

        finish_run();
    end

endmodule